// File: doc/BRIEF.md
# Two-State Dicode Sequence Detector

This block recovers binary data from a channel whose response is one sample minus the previous one. Each noiseless received value is therefore −a, 0 or +a. The block makes a maximum-likelihood decision over the whole sequence instead of slicing each sample on its own. Because the trellis has only two states, it does not track two absolute path costs. It keeps one signed number, the state-0 cost minus the state-1 cost. Each step pushes that number into a window centred on the current sample with half-width a/2. Whichever edge of the window the number crosses tells which predecessor both states share.

Every accepted sample also updates two survivor shift registers, one for each state. When the window clamps, the winning register is copied into both registers before the shift. The oldest stage of the state-0 register gives the decided bit, DEPTH samples late. The upstream logic supplies samples that are already equalised, along with the half-amplitude a/2. It asserts a valid strobe on the cycles that carry a sample. The detector can be instantiated twice to serve the even and odd halves of a class-4 stream.

Top module: `dicode_viterbi`

## Requirements
- R1: While rst_n is low, and until the first valid sample, out_valid and out_bit are 0. The metric and both survivor registers reset to 0.
- R2: With lo = y − h and hi = y + h (h = half_amp), a valid sample sets the metric to lo if it was below lo and to hi if it was above hi. Otherwise, including when it is exactly equal to lo or hi, the metric is left unchanged. The metric is two bits wider than the sample, so these sums never wrap.
- R3: On a valid sample, a metric below lo makes both survivors continue the state-0 register. A metric above hi makes both continue the state-1 register. Otherwise each register continues its own contents.
- R4: After every valid sample, stage 0 of the state-0 survivor holds 0 and stage 0 of the state-1 survivor holds 1.
- R5: out_valid is in_valid delayed by one cycle. On a valid sample, out_bit takes the value the oldest state-0 stage held before that update.
- R6: With noiseless input y = a·(b(k) − b(k−1)), starting from b = 0, and no run of equal bits longer than 8, the output that follows sample j equals b(j − DEPTH). The first DEPTH outputs are 0.
- R7: A cycle with in_valid low changes neither the metric nor the survivors. The following cycle has out_valid = 0 and out_bit held, whatever value is on sample.
- R8: One large noise sample is corrected. Take bits 1,1,0,1,0,0 received as 16,6,−8,18,−16,−2 with a = 20: they are decided correctly, even though slicing the third sample alone gives the wrong symbol.
- R9: Noise of magnitude at most 2 on every sample, with a = 24, causes no decision errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a cycle that carries a sample |
| sample | input | SW | Signed equalised received sample |
| half_amp | input | SW | Unsigned half of the ideal nonzero level, a/2 |
| out_valid | output | 1 | A decided bit is presented this cycle |
| out_bit | output | 1 | Decided data bit, DEPTH samples late |

## Verification
In one cycle the block can clamp the metric and copy one survivor register into the other, while also shifting the oldest state-0 stage out to out_bit. The copy must use the register contents from before the shift, and the output must use the stage from before the copy. The bench provokes this with dense noisy streams in which merges come every few samples, including the noisy sample of the example sequence. It judges the result by comparing every delayed decision against the transmitted bit. Idle gaps are placed directly before and after merging samples, to show that a held cycle neither finishes nor starts a copy.

// File: rtl/dicode_viterbi.sv
module dicode_viterbi #(
  parameter int SW    = 6,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] sample,
  input  logic        [SW-1:0] half_amp,
  output logic                 out_valid,
  output logic                 out_bit
);
  localparam int MW = SW + 2;

  logic signed [MW-1:0] y_ext, h_ext, lo, hi, delta;
  logic [DEPTH-1:0] surv0, surv1, src0, src1;
  logic take0, take1;

  assign y_ext = MW'(sample);
  assign h_ext = MW'(half_amp);
  assign lo    = y_ext - h_ext;
  assign hi    = y_ext + h_ext;
  assign take0 = delta < lo;
  assign take1 = delta > hi;
  assign src0  = take1 ? surv1 : surv0;
  assign src1  = take0 ? surv0 : surv1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta     <= '0;
      surv0     <= '0;
      surv1     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (take0)      delta <= lo;
        else if (take1) delta <= hi;
        surv0   <= {src0[DEPTH-2:0], 1'b0};
        surv1   <= {src1[DEPTH-2:0], 1'b1};
        out_bit <= surv0[DEPTH-1];
      end
    end
  end
endmodule

module dicode_viterbi_chk #(
  parameter int SW    = 6,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic signed [SW-1:0]   sample,
  input logic        [SW-1:0]   half_amp,
  input logic signed [SW+1:0]   delta,
  input logic        [DEPTH-1:0] p0,
  input logic        [DEPTH-1:0] p1,
  input logic                   out_valid,
  input logic                   out_bit
);
  logic signed [SW+1:0] wlo, whi;
  assign wlo = (SW+2)'(sample) - (SW+2)'(half_amp);
  assign whi = (SW+2)'(sample) + (SW+2)'(half_amp);

  // R2
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (delta >= $past(wlo) && delta <= $past(whi)));
  // R2
  hold_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && delta >= wlo && delta <= whi) |=> $stable(delta));
  // R3
  merge_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (p0[DEPTH-1:1] == $past(p0[DEPTH-2:0]) || p0[DEPTH-1:1] == $past(p1[DEPTH-2:0])));
  // R3
  merge_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (p1[DEPTH-1:1] == $past(p0[DEPTH-2:0]) || p1[DEPTH-1:1] == $past(p1[DEPTH-2:0])));
  // R4
  label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (p0[0] == 1'b0 && p1[0] == 1'b1));
  // R5
  out_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_bit == $past(p0[DEPTH-1])));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(delta) && $stable(p0) && $stable(p1) && $stable(out_bit)));
endmodule

bind dicode_viterbi dicode_viterbi_chk #(.SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample), .half_amp(half_amp),
  .delta(delta), .p0(surv0), .p1(surv1), .out_valid(out_valid), .out_bit(out_bit)
);

// File: tb/tb_dicode_viterbi.sv
`timescale 1ns/1ps
module tb_dicode_viterbi;
  localparam int SW = 6, DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, out_valid, out_bit;
  logic signed [SW-1:0] sample;
  logic [SW-1:0] half_amp;

  int checks = 0, errors = 0;
  int hist[$];
  int prev_bit, a_amp;
  bit last_out;

  dicode_viterbi #(.SW(SW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
    .half_amp(half_amp), .out_valid(out_valid), .out_bit(out_bit));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int a);
    in_valid = 0; sample = '0; half_amp = SW'(a / 2); rst_n = 0;
    a_amp = a; prev_bit = 0; hist.delete();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_bit in reset", out_bit, 0);
    @(negedge clk) rst_n = 1;
    last_out = 0;
  endtask

  function automatic int expected_bit();
    return (hist.size() > DEPTH) ? hist[hist.size() - DEPTH - 1] : 0;
  endfunction

  task automatic send_raw(int b, int y, string tag);
    prev_bit = b;
    hist.push_back(b);
    @(negedge clk);
    in_valid = 1; sample = SW'(y);
    @(posedge clk); #1;
    chk({tag, " R5 out_valid"}, out_valid, 1);
    chk(tag, out_bit, expected_bit());
    last_out = out_bit;
  endtask

  task automatic send(int b, int noise, string tag);
    send_raw(b, a_amp * (b - prev_bit) + noise, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; sample = SW'($urandom_range(63));
      @(posedge clk); #1;
      chk("R7 out_valid idle", out_valid, 0);
      chk("R7 out_bit held", out_bit, last_out);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] lfsr;
    int run, b, lastb;
    void'($urandom(7));

    // R1 reset, then R8 example sequence and R6 noiseless PRBS continuation
    do_reset(20);
    #1;
    chk("R1 out_valid after reset", out_valid, 0);
    send_raw(1, 16, "R8"); send_raw(1, 6, "R8"); send_raw(0, -8, "R8");
    send_raw(1, 18, "R8"); send_raw(0, -16, "R8"); send_raw(0, -2, "R8");
    lfsr = 7'h5a;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      send(lfsr[0], 0, (hist.size() < DEPTH + 6) ? "R8 corrected" : "R6 delayed bit");
    end

    // R9 small noise, R7 random idle gaps, R2/R3/R4 merges exercised
    do_reset(24);
    run = 0; lastb = 0;
    for (int i = 0; i < 500; i++) begin
      b = $urandom_range(1);
      if (b == lastb) run++; else run = 0;
      if (run >= 6) begin b = 1 - lastb; run = 0; end
      lastb = b;
      send(b, $urandom_range(4) - 2, "R9 noisy stream R2 R3 R4");
      if ($urandom_range(3) == 0) idle($urandom_range(2) + 1);
    end

    // R6 full-scale levels and maximal alternation, with gaps around merges
    do_reset(30);
    for (int i = 0; i < 60; i++) begin
      send(i % 2, 0, "R6 full scale");
      if (i % 7 == 3) idle(1);
    end
    for (int i = 0; i < 40; i++) send((i / 8) % 2, 0, "R6 long runs");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule